// File: doc/BRIEF.md
# Video Control Port Command Decoder

This block sits on the control port of a display controller. Every 32-bit write carries a command in its top byte and arguments in the remaining bits. The block decodes each write and updates a 32-bit status word, the display origin in video memory, the vertical line range, and a video-standard flag. It also updates a readback word for the information queries. It resolves the active display width and height from mode fields held in the status word. Two lookup tables are used, and their steps are uneven.

The block emits one-cycle pulses to its neighbours. The packet assembler receives a flush pulse. The image transfer engine receives a transfer-stop pulse. The drawing engine receives a soft-reset pulse, on which it reloads its own defaults: a texture window of 0,0,255,255 and a drawing area of 256x240. The drawing engine in turn supplies its current area corner, size and offset, and the block returns these for the queries. A frame tick input flips the odd/even field bit of the status word once per frame. The status word can be read at any time.

Top module: `vid_ctrl_decode`

## Requirements
- R1: After rst_ni is released, the outputs hold these values:
  - status_o is 0x14802000, width_o is 256, height_o is 240 and line_end_o is 240.
  - org_x_o, org_y_o, line_start_o, pal_o and info_o are 0.
  - All pulse outputs are 0.
- R2: A write with command byte (bits 31:24) equal to 0x00 acts as a soft reset:
  - It loads status_o with 0x14802000, which gives width 256 and height 240.
  - It sets line_end_o to 240 and pulses soft_rst_o for one cycle.
  - It leaves org_x_o, org_y_o, line_start_o, pal_o and info_o unchanged.
- R3: Command 0x01 or 0x02 clears status bit 27. It also pulses both flush_o and xfer_stop_o for one cycle. No other status bit changes.
- R4: Command 0x03 copies data bit 0 into status bit 23. Command 0x04 copies data bits 1:0 into status bits 30:29. Only the exact word 0x04000000 also pulses flush_o. Other 0x04 words do not pulse flush_o or xfer_stop_o.
- R5: Command 0x05 loads org_x_o from data bits 9:0 and org_y_o from data bits 18:10.
- R6: Command 0x07 loads line_start_o from data bits 9:0 and line_end_o from data bits 19:10.
- R7: Command 0x08 writes data bits 5:0 into status bits 22:17 and data bit 6 into status bit 16. It loads pal_o from data bit 3. Every other status bit is kept.
- R8: width_o is selected by status bits 18:16 as index 0..7 from the list 256, 368, 320, 384, 512, 512, 640, 640. height_o is selected by status bits 20:19 as index 0..3 from the list 240, 480, 256, 480.
- R9: Command 0x10 loads info_o from the sub-code in data bits 15:0:
  - Sub-codes 0, 1 and 3 give {draw_y, draw_x} with draw_x in bits 9:0.
  - Sub-code 4 gives {draw_h-1, draw_w-1} with each field 10 bits wide and draw_w-1 in bits 9:0.
  - Sub-codes 5 and 6 give {ofs_y, ofs_x} with ofs_x in bits 10:0.
  - Sub-code 7 gives 2. Any other sub-code gives 0.
  - info_o holds its value between queries.
- R10: Each cycle with frame_tick_i high inverts status bit 31. If a write happens in the same cycle, the write is applied first and the inversion second. A soft reset together with a tick therefore gives 0x94802000.
- R11: A write whose command byte is not listed above changes no output and raises no pulse. With neither a write nor a tick, status_o is stable.
- R12: Each register output and each pulse changes on the first clock edge that samples the write. It is visible in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control-port write strobe |
| wr_data_i | input | 32 | Command (bits 31:24) and arguments |
| frame_tick_i | input | 1 | One-cycle tick per frame |
| draw_x_i | input | 10 | Drawing area left column |
| draw_y_i | input | 10 | Drawing area top line |
| draw_w_i | input | 11 | Drawing area width |
| draw_h_i | input | 10 | Drawing area height |
| ofs_x_i | input | 11 | Drawing offset X |
| ofs_y_i | input | 11 | Drawing offset Y |
| status_o | output | 32 | Status word |
| width_o | output | 10 | Resolved display width |
| height_o | output | 9 | Resolved display height |
| org_x_o | output | 10 | Display origin column |
| org_y_o | output | 9 | Display origin line |
| line_start_o | output | 10 | First displayed line |
| line_end_o | output | 10 | Line after the last displayed line |
| pal_o | output | 1 | 50 Hz video standard selected |
| info_o | output | 32 | Query readback word |
| flush_o | output | 1 | Pulse: discard the partial command packet |
| xfer_stop_o | output | 1 | Pulse: end any image transfer |
| soft_rst_o | output | 1 | Pulse: drawing engine reloads its defaults |

## Verification
The assertions check the following properties on every cycle:
- The frame tick always flips the field bit.
- The status word holds when neither a write nor a tick occurs.
- A soft reset without a tick lands exactly on the default word.
- The flush and transfer-stop pulses only follow an abort write.
- At most one command strobe is ever active.
- The resolved width and height are always legal table entries.

Only the bench scenarios can show the exact bit placement of the mode fields, the table order, and the query packings including the wrap of a zero size minus one. The same holds for the byte-exact match needed for a flush from command 0x04, the collision of a tick with a soft reset, and the silence of unlisted commands.

// File: rtl/vcd_pkg.sv
package vcd_pkg;

  localparam int unsigned CMD_W = 8;
  localparam logic [31:0] STAT_RST  = 32'h1480_2000;
  localparam logic [31:0] FLUSH_EXACT = 32'h0400_0000;
  localparam int unsigned LINE_END_RST = 240;

  // status bit positions decoded by neighbours
  localparam int unsigned FIELD_BIT = 31;
  localparam int unsigned BUSY_BIT  = 27;
  localparam int unsigned BLANK_BIT = 23;

  typedef enum logic [CMD_W-1:0] {
    CMD_SOFT_RST   = 8'h00,
    CMD_FLUSH_A    = 8'h01,
    CMD_FLUSH_B    = 8'h02,
    CMD_DISP_OFF   = 8'h03,
    CMD_XFER_DIR   = 8'h04,
    CMD_ORIGIN     = 8'h05,
    CMD_LINE_RANGE = 8'h07,
    CMD_VMODE      = 8'h08,
    CMD_QUERY      = 8'h10
  } vcd_cmd_e;

  typedef struct packed {
    logic soft_rst;
    logic flush;
    logic disp_off;
    logic xfer_dir;
    logic origin;
    logic line_range;
    logic vmode;
    logic query;
  } vcd_hit_t;

  function automatic logic [9:0] width_lut(input logic [2:0] idx);
    case (idx)
      3'd0:        return 10'd256;
      3'd1:        return 10'd368;
      3'd2:        return 10'd320;
      3'd3:        return 10'd384;
      3'd4, 3'd5:  return 10'd512;
      default:     return 10'd640;
    endcase
  endfunction

  function automatic logic [8:0] height_lut(input logic [1:0] idx);
    case (idx)
      2'd0:    return 9'd240;
      2'd2:    return 9'd256;
      default: return 9'd480;
    endcase
  endfunction

endpackage

// File: rtl/vcd_cmd_dec.sv
module vcd_cmd_dec
  import vcd_pkg::*;
(
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output vcd_hit_t    hit_o,
  output logic        flush_exact_o
);
  logic [CMD_W-1:0] cmd;
  assign cmd = wr_data_i[31:32-CMD_W];

  always_comb begin
    hit_o            = '0;
    hit_o.soft_rst   = wr_en_i && (cmd == CMD_SOFT_RST);
    hit_o.flush      = wr_en_i && (cmd == CMD_FLUSH_A || cmd == CMD_FLUSH_B);
    hit_o.disp_off   = wr_en_i && (cmd == CMD_DISP_OFF);
    hit_o.xfer_dir   = wr_en_i && (cmd == CMD_XFER_DIR);
    hit_o.origin     = wr_en_i && (cmd == CMD_ORIGIN);
    hit_o.line_range = wr_en_i && (cmd == CMD_LINE_RANGE);
    hit_o.vmode      = wr_en_i && (cmd == CMD_VMODE);
    hit_o.query      = wr_en_i && (cmd == CMD_QUERY);
  end

  assign flush_exact_o = wr_en_i && (wr_data_i == FLUSH_EXACT);
endmodule

// File: rtl/vcd_status_reg.sv
module vcd_status_reg
  import vcd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  vcd_hit_t    hit_i,
  input  logic [6:0]  arg_i,
  input  logic        frame_tick_i,
  output logic [31:0] status_o
);
  logic [31:0] status_q, status_d;

  always_comb begin
    status_d = status_q;
    if (hit_i.soft_rst) status_d = STAT_RST;
    if (hit_i.flush)    status_d[BUSY_BIT] = 1'b0;
    if (hit_i.disp_off) status_d[BLANK_BIT] = arg_i[0];
    if (hit_i.xfer_dir) status_d[30:29] = arg_i[1:0];
    if (hit_i.vmode) begin
      status_d[22:17] = arg_i[5:0];
      status_d[16]    = arg_i[6];
    end
    // tick applies after any write of the same cycle
    if (frame_tick_i) status_d[FIELD_BIT] = ~status_d[FIELD_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) status_q <= STAT_RST;
    else         status_q <= status_d;

  assign status_o = status_q;

  // R10
  field_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_tick_i && !hit_i.soft_rst |=> status_q[FIELD_BIT] != $past(status_q[FIELD_BIT]));
  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_tick_i && (hit_i == '0) |=> $stable(status_q));
  // R2
  soft_rst_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i.soft_rst && !frame_tick_i |=> status_q == STAT_RST);
endmodule

// File: rtl/vcd_mode_lut.sv
module vcd_mode_lut
  import vcd_pkg::*;
(
  input  logic [4:0] mode_i,
  output logic [9:0] width_o,
  output logic [8:0] height_o
);
  assign width_o  = width_lut(mode_i[2:0]);
  assign height_o = height_lut(mode_i[4:3]);
endmodule

// File: rtl/vcd_info_q.sv
module vcd_info_q #(
  parameter int unsigned XY_W = 10,
  parameter int unsigned SZ_W = 11,
  parameter int unsigned OF_W = 11
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            query_i,
  input  logic [15:0]     sub_i,
  input  logic [XY_W-1:0] draw_x_i,
  input  logic [XY_W-1:0] draw_y_i,
  input  logic [SZ_W-1:0] draw_w_i,
  input  logic [XY_W-1:0] draw_h_i,
  input  logic [OF_W-1:0] ofs_x_i,
  input  logic [OF_W-1:0] ofs_y_i,
  output logic [31:0]     info_o
);
  localparam int unsigned PAD_XY = 32 - 2*XY_W;
  localparam int unsigned PAD_OF = 32 - 2*OF_W;

  logic [SZ_W-1:0] w_m1;
  logic [XY_W-1:0] h_m1;
  logic [31:0]     info_d, info_q;

  assign w_m1 = draw_w_i - SZ_W'(1);
  assign h_m1 = draw_h_i - XY_W'(1);

  always_comb begin
    case (sub_i)
      16'd0, 16'd1, 16'd3: info_d = {PAD_XY'(0), draw_y_i, draw_x_i};
      16'd4:               info_d = {PAD_XY'(0), h_m1, w_m1[XY_W-1:0]};
      16'd5, 16'd6:        info_d = {PAD_OF'(0), ofs_y_i, ofs_x_i};
      16'd7:               info_d = 32'd2;
      default:             info_d = 32'd0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      info_q <= '0;
    else if (query_i) info_q <= info_d;

  assign info_o = info_q;

  // R9
  info_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !query_i |=> $stable(info_q));
endmodule

// File: rtl/vid_ctrl_decode.sv
module vid_ctrl_decode
  import vcd_pkg::*;
#(
  parameter int unsigned ORG_X_W = 10,
  parameter int unsigned ORG_Y_W = 9,
  parameter int unsigned LINE_W  = 10,
  parameter int unsigned DRW_W   = 10,
  parameter int unsigned SZ_W    = 11,
  parameter int unsigned OFS_W   = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [31:0]        wr_data_i,
  input  logic               frame_tick_i,
  input  logic [DRW_W-1:0]   draw_x_i,
  input  logic [DRW_W-1:0]   draw_y_i,
  input  logic [SZ_W-1:0]    draw_w_i,
  input  logic [DRW_W-1:0]   draw_h_i,
  input  logic [OFS_W-1:0]   ofs_x_i,
  input  logic [OFS_W-1:0]   ofs_y_i,
  output logic [31:0]        status_o,
  output logic [9:0]         width_o,
  output logic [8:0]         height_o,
  output logic [ORG_X_W-1:0] org_x_o,
  output logic [ORG_Y_W-1:0] org_y_o,
  output logic [LINE_W-1:0]  line_start_o,
  output logic [LINE_W-1:0]  line_end_o,
  output logic               pal_o,
  output logic [31:0]        info_o,
  output logic               flush_o,
  output logic               xfer_stop_o,
  output logic               soft_rst_o
);
  localparam int unsigned Y_LSB   = ORG_X_W;
  localparam int unsigned END_LSB = LINE_W;
  localparam int unsigned PAL_BIT = 3;

  vcd_hit_t hit;
  logic     flush_exact;

  vcd_cmd_dec i_dec (
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .hit_o        (hit),
    .flush_exact_o(flush_exact)
  );

  vcd_status_reg i_stat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hit_i       (hit),
    .arg_i       (wr_data_i[6:0]),
    .frame_tick_i(frame_tick_i),
    .status_o    (status_o)
  );

  vcd_mode_lut i_lut (
    .mode_i  (status_o[20:16]),
    .width_o (width_o),
    .height_o(height_o)
  );

  vcd_info_q #(.XY_W(DRW_W), .SZ_W(SZ_W), .OF_W(OFS_W)) i_info (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .query_i (hit.query),
    .sub_i   (wr_data_i[15:0]),
    .draw_x_i(draw_x_i),
    .draw_y_i(draw_y_i),
    .draw_w_i(draw_w_i),
    .draw_h_i(draw_h_i),
    .ofs_x_i (ofs_x_i),
    .ofs_y_i (ofs_y_i),
    .info_o  (info_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      org_x_o      <= '0;
      org_y_o      <= '0;
      line_start_o <= '0;
      line_end_o   <= LINE_W'(LINE_END_RST);
      pal_o        <= 1'b0;
      flush_o      <= 1'b0;
      xfer_stop_o  <= 1'b0;
      soft_rst_o   <= 1'b0;
    end else begin
      flush_o     <= hit.flush | flush_exact;
      xfer_stop_o <= hit.flush;
      soft_rst_o  <= hit.soft_rst;
      if (hit.soft_rst) line_end_o <= LINE_W'(LINE_END_RST);
      if (hit.origin) begin
        org_x_o <= wr_data_i[ORG_X_W-1:0];
        org_y_o <= wr_data_i[Y_LSB +: ORG_Y_W];
      end
      if (hit.line_range) begin
        line_start_o <= wr_data_i[LINE_W-1:0];
        line_end_o   <= wr_data_i[END_LSB +: LINE_W];
      end
      if (hit.vmode) pal_o <= wr_data_i[PAL_BIT];
    end
  end

  // R3
  flush_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> $past(wr_en_i) && ($past(wr_data_i[31:24]) inside {8'h01, 8'h02}
                                  || $past(wr_data_i) == FLUSH_EXACT));
  // R3
  stop_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_stop_o |-> flush_o);
  // R11
  one_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit));
  // R8
  mode_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (width_o inside {10'd256, 10'd320, 10'd368, 10'd384, 10'd512, 10'd640})
    && (height_o inside {9'd240, 9'd256, 9'd480}));
endmodule

// File: tb/test_vid_ctrl_decode.sv
module test_vid_ctrl_decode;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        tick = 1'b0;
  logic [9:0]  draw_x = '0, draw_y = '0, draw_h = '0;
  logic [10:0] draw_w = '0, ofs_x = '0, ofs_y = '0;
  logic [31:0] status, info;
  logic [9:0]  width, org_x, line_start, line_end;
  logic [8:0]  height, org_y;
  logic        pal, flush, xstop, srst;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vid_ctrl_decode i_vid_ctrl_decode (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .frame_tick_i(tick), .draw_x_i(draw_x), .draw_y_i(draw_y),
    .draw_w_i(draw_w), .draw_h_i(draw_h), .ofs_x_i(ofs_x), .ofs_y_i(ofs_y),
    .status_o(status), .width_o(width), .height_o(height), .org_x_o(org_x),
    .org_y_o(org_y), .line_start_o(line_start), .line_end_o(line_end),
    .pal_o(pal), .info_o(info), .flush_o(flush), .xfer_stop_o(xstop),
    .soft_rst_o(srst)
  );

  // reference state
  logic [31:0] m_status = 32'h1480_2000, m_info = '0;
  logic [9:0]  m_x = '0, m_rs = '0, m_re = 10'd240;
  logic [8:0]  m_y = '0;
  logic        m_pal = 1'b0, m_fl = 1'b0, m_xs = 1'b0, m_sr = 1'b0;

  function automatic logic [9:0] exp_w(input logic [2:0] i);
    logic [9:0] t [8] = '{10'd256, 10'd368, 10'd320, 10'd384,
                          10'd512, 10'd512, 10'd640, 10'd640};
    return t[i];
  endfunction

  function automatic logic [8:0] exp_h(input logic [1:0] i);
    logic [8:0] t [4] = '{9'd240, 9'd480, 9'd256, 9'd480};
    return t[i];
  endfunction

  function automatic logic [31:0] exp_info(input logic [15:0] s);
    logic [10:0] wm = draw_w - 11'd1;
    logic [9:0]  hm = draw_h - 10'd1;
    if (s == 0 || s == 1 || s == 3) return {12'd0, draw_y, draw_x};
    if (s == 4) return {12'd0, hm, wm[9:0]};
    if (s == 5 || s == 6) return {10'd0, ofs_y, ofs_x};
    if (s == 7) return 32'd2;
    return 32'd0;
  endfunction

  function automatic string req_of(input logic [7:0] c);
    case (c)
      8'h00: return "R2";
      8'h01, 8'h02: return "R3";
      8'h03, 8'h04: return "R4";
      8'h05: return "R5";
      8'h07: return "R6";
      8'h08: return "R7";
      8'h10: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string rq, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic check_all(input string rq);
    chk(rq, "status", status, m_status);
    chk({rq, "/R8"}, "width", 32'(width), 32'(exp_w(m_status[18:16])));
    chk({rq, "/R8"}, "height", 32'(height), 32'(exp_h(m_status[20:19])));
    chk(rq, "org_x", 32'(org_x), 32'(m_x));
    chk(rq, "org_y", 32'(org_y), 32'(m_y));
    chk(rq, "line_start", 32'(line_start), 32'(m_rs));
    chk(rq, "line_end", 32'(line_end), 32'(m_re));
    chk(rq, "pal", 32'(pal), 32'(m_pal));
    chk(rq, "info", info, m_info);
    chk({rq, "/R12"}, "flush", 32'(flush), 32'(m_fl));
    chk({rq, "/R12"}, "xfer_stop", 32'(xstop), 32'(m_xs));
    chk({rq, "/R12"}, "soft_rst", 32'(srst), 32'(m_sr));
  endtask

  task automatic model(input bit wr, input logic [31:0] d, input bit tk);
    logic [7:0] c = d[31:24];
    m_fl = wr && (c == 8'h01 || c == 8'h02 || d == 32'h0400_0000);
    m_xs = wr && (c == 8'h01 || c == 8'h02);
    m_sr = wr && c == 8'h00;
    if (wr) begin
      case (c)
        8'h00: begin m_status = 32'h1480_2000; m_re = 10'd240; end
        8'h01, 8'h02: m_status[27] = 1'b0;
        8'h03: m_status[23] = d[0];
        8'h04: m_status[30:29] = d[1:0];
        8'h05: begin m_x = d[9:0]; m_y = d[18:10]; end
        8'h07: begin m_rs = d[9:0]; m_re = d[19:10]; end
        8'h08: begin m_status[22:17] = d[5:0]; m_status[16] = d[6]; m_pal = d[3]; end
        8'h10: m_info = exp_info(d[15:0]);
        default: ;
      endcase
    end
    if (tk) m_status[31] = ~m_status[31];
  endtask

  // called at a negative edge; checks after the next one
  task automatic step(input bit wr, input logic [31:0] d, input bit tk, input string rq);
    wr_en = wr; wr_data = d; tick = tk;
    @(posedge clk);
    model(wr, d, tk);
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    check_all(rq);
  endtask

  initial begin
    #600000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // mode tables: every width and height index (R8)
    for (int i = 0; i < 8; i++) step(1, {8'h08, 17'd0, i[0], 4'd0, i[2:1]}, 0, "R8");
    for (int i = 0; i < 4; i++) step(1, {8'h08, 20'd0, i[1:0], 2'd0}, 0, "R8");
    step(1, 32'h0800_0008, 0, "R7");
    step(1, 32'h0800_007F, 0, "R7");
    // status bits 27 and 23, direction field
    step(1, 32'h0300_0001, 0, "R4");
    step(1, 32'h0400_0003, 0, "R4");
    step(1, 32'h0400_0001, 0, "R4");
    step(1, 32'h0400_0000, 0, "R4");
    step(1, 32'h0100_0000, 0, "R3");
    step(1, 32'h02FF_FFFF, 0, "R3");
    step(1, 32'h0506_0A55, 0, "R5");
    step(1, 32'h07FF_FFFF, 0, "R6");
    step(1, 32'h0701_2C10, 0, "R6");
    // info queries
    draw_x = 10'h155; draw_y = 10'h2AA; draw_w = 11'd0; draw_h = 10'd0;
    ofs_x = 11'h7FF; ofs_y = 11'h401;
    for (int s = 0; s < 9; s++) step(1, {8'h10, 8'h00, s[15:0]}, 0, "R9");
    step(1, 32'h10FF_FFFF, 0, "R9");
    step(1, 32'h1000_0000, 0, "R9");
    step(0, 32'h1000_0004, 0, "R9");
    // unlisted commands
    step(1, 32'h06FF_FFFF, 0, "R11");
    step(1, 32'h09FF_FFFF, 0, "R11");
    step(1, 32'hFF00_0000, 0, "R11");
    // ticks, alone and with writes
    step(0, 32'h0, 1, "R10");
    step(0, 32'h0, 1, "R10");
    step(1, 32'h0800_0015, 1, "R10");
    step(1, 32'h0000_0000, 1, "R10");
    step(1, 32'h0000_0000, 0, "R2");
    step(0, 32'h0, 0, "R12");

    // constrained random mix
    for (int n = 0; n < 2000; n++) begin
      logic [7:0]  c;
      logic [31:0] d;
      bit          wr, tk;
      int          pick = $urandom_range(0, 11);
      case (pick)
        0: c = 8'h00;  1: c = 8'h01;  2: c = 8'h02;  3: c = 8'h03;
        4: c = 8'h04;  5: c = 8'h05;  6: c = 8'h07;  7: c = 8'h08;
        8: c = 8'h10;  default: c = 8'($urandom);
      endcase
      d = {c, 24'($urandom)};
      if (c == 8'h10) d[15:0] = 16'($urandom_range(0, 9));
      if (c == 8'h04 && $urandom_range(0, 3) == 0) d = 32'h0400_0000;
      wr = ($urandom_range(0, 3) != 0);
      tk = ($urandom_range(0, 3) == 0);
      draw_x = 10'($urandom); draw_y = 10'($urandom); draw_w = 11'($urandom);
      draw_h = 10'($urandom); ofs_x = 11'($urandom); ofs_y = 11'($urandom);
      step(wr, d, tk, wr ? req_of(c) : "R11");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule